// File: doc/BRIEF.md
# Secure power-control register bank with single-bit set and clear windows

This block holds a small bank of 32-bit power-management control words behind a simple single-cycle memory-mapped request port. Each request carries an attribute saying whether the issuing master is secure. Any master may read any word. Only secure masters may change a word. A refused write leaves storage untouched and is answered with an error flag.

Besides the plain full-word window, two alias windows let a master change exactly one bit of a word without a read-modify-write. The two top address bits select the window. The write data in an alias window is a bit number, not a mask. Because each alias write touches a single bit, several masters can share a control word without overwriting each other's updates. Every request gets a registered response in the cycle after it is presented.

Top module: `pwr_ctl_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every stored word reads as zero and rsp_valid is low.
- R2: A secure write with addr[15:14] = 2'b00 to an implemented, word-aligned offset stores the whole of req_wdata and answers rsp_err = 0.
- R3: A secure write with addr[15:14] = 2'b11 sets bit req_wdata of the word at word index addr[13:2]. All other bits of that word and all other words keep their values, and rsp_err = 0.
- R4: A secure write with addr[15:14] = 2'b10 clears bit req_wdata of the addressed word, leaves every other bit unchanged, and answers rsp_err = 0.
- R5: A write with req_secure = 0, in any window, changes no word and answers rsp_err = 1.
- R6: A read from either secure or non-secure masters at an implemented aligned offset returns the stored word on rsp_rdata with rsp_err = 0.
- R7: A read through either alias window (addr[15:14] = 2'b11 or 2'b10) returns the addressed word and changes nothing.
- R8: A write with addr[15:14] = 2'b01 is ignored and answered with rsp_err = 1.
- R9: An alias-window write whose req_wdata is greater than 31 changes nothing and answers rsp_err = 1.
- R10: An access whose word index addr[13:2] is NUM_REGS or above answers rsp_err = 1. A write of this kind changes no word, and a read of this kind returns zero.
- R11: rsp_valid is high in exactly the cycle after each cycle with req_valid high, and low otherwise.
- R12: An access with addr[1:0] not equal to 2'b00 answers rsp_err = 1. A write of this kind changes no word, and a read of this kind returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | The issuing master is secure |
| req_addr | input | 16 | Byte address: [15:14] window, [13:2] word index, [1:0] must be zero |
| req_wdata | input | 32 | Full word (plain window) or bit number (alias windows) |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | The request was refused or malformed |
| rsp_rdata | output | 32 | Read data; zero for writes and refused reads |

## Verification
The properties assume that req_valid is held low while rst_n is low, so that no request attempt straddles the reset release. They also assume that request fields are stable for the whole cycle in which they are sampled. The bench drives every request on the falling edge and drops req_valid before the next falling edge. It holds req_valid low for the whole reset period. Every stored value the bench expects is computed from the requirements and confirmed through ordinary reads on the port.

// File: rtl/pwr_bank_pkg.sv
// Shared types for the power-control register bank.
// The window encoding is taken from the two top address bits.
package pwr_bank_pkg;
    typedef enum logic [1:0] {
        WIN_PLAIN = 2'b00,
        WIN_RSVD  = 2'b01,
        WIN_CLR   = 2'b10,
        WIN_SET   = 2'b11
    } win_e;
endpackage

// File: rtl/pwr_bank_decode.sv
// Address and data decode for the register bank.
// Splits the byte address into window, word index, range and alignment
// flags, and checks that an alias bit number fits in a word.
// Assumes NUM_REGS fits in the word-index field of the address.
module pwr_bank_decode
    import pwr_bank_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4,
    parameter int BIT_W    = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output win_e              win,
    output logic [IDX_W-1:0]  idx,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              in_range,
    output logic              aligned,
    output logic              bit_ok
);
    localparam int WORD_W = ADDR_W - 4;

    logic [WORD_W-1:0] word;

    // Field split and validity flags.
    always_comb begin
        win      = win_e'(addr[ADDR_W-1 -: 2]);
        word     = addr[ADDR_W-3:2];
        idx      = word[IDX_W-1:0];
        in_range = (32'(word) < 32'(NUM_REGS));
        aligned  = (addr[1:0] == 2'b00);
        bit_ok   = (wdata < 32'(DATA_W));
        bit_idx  = wdata[BIT_W-1:0];
    end
endmodule

// File: rtl/pwr_bank_regfile.sv
// Storage for the control words, one generated slot per word.
// A plain update replaces the word; set and clear updates touch one bit.
// Assumes wr_en is only raised for an accepted, in-range access.
module pwr_bank_regfile
    import pwr_bank_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4,
    parameter int BIT_W    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  win_e                       win,
    input  logic [IDX_W-1:0]           idx,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [BIT_W-1:0]           bit_idx,
    output logic [NUM_REGS*DATA_W-1:0] words
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        logic [DATA_W-1:0] q;
        logic [DATA_W-1:0] nxt;

        // Next value of this word for the current update.
        always_comb begin
            nxt = q;
            if (wr_en && (idx == IDX_W'(g))) begin
                case (win)
                    WIN_PLAIN: nxt = wdata;
                    WIN_SET:   nxt[bit_idx] = 1'b1;
                    WIN_CLR:   nxt[bit_idx] = 1'b0;
                    default:   nxt = q;
                endcase
            end
        end

        // Word register with synchronous reset to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= nxt;
        end

        assign words[g*DATA_W +: DATA_W] = q;
    end
endmodule

// File: rtl/pwr_bank_rsp.sv
// Registered response stage: valid, error and read data one cycle after
// the request. Assumes err and rdata are already qualified by the caller.
module pwr_bank_rsp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              err,
    input  logic [DATA_W-1:0] rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Capture the response for the request presented this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid & err;
            rsp_rdata <= req_valid ? rdata : '0;
        end
    end
endmodule

// File: rtl/pwr_ctl_bank.sv
// Power-control register bank with secure-only writes and single-bit
// set/clear alias windows. Reads are open to every master.
// Assumes one request per cycle and a 32-bit word.
module pwr_ctl_bank
    import pwr_bank_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int BIT_W = $clog2(DATA_W);

    win_e                       win;
    logic [IDX_W-1:0]           idx;
    logic [BIT_W-1:0]           bit_idx;
    logic                       in_range, aligned, bit_ok;
    logic                       win_ok, wr_ok, acc_err;
    logic [DATA_W-1:0]          rd_word;
    logic [NUM_REGS*DATA_W-1:0] words;

    pwr_bank_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
        .IDX_W(IDX_W), .BIT_W(BIT_W)
    ) u_dec (
        .addr(req_addr), .wdata(req_wdata), .win(win), .idx(idx),
        .bit_idx(bit_idx), .in_range(in_range), .aligned(aligned),
        .bit_ok(bit_ok)
    );

    // Access check: which writes are accepted and which requests fail.
    always_comb begin
        case (win)
            WIN_PLAIN:       win_ok = 1'b1;
            WIN_SET, WIN_CLR: win_ok = bit_ok;
            default:         win_ok = 1'b0;
        endcase
        wr_ok   = req_secure & in_range & aligned & win_ok;
        acc_err = req_write ? ~wr_ok : ~(in_range & aligned);
    end

    // Read mux: open to all masters, zero when the word does not exist.
    always_comb begin
        rd_word = '0;
        if (!req_write && in_range && aligned)
            rd_word = words[int'(idx)*DATA_W +: DATA_W];
    end

    pwr_bank_regfile #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .BIT_W(BIT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(req_valid & req_write & wr_ok),
        .win(win), .idx(idx), .wdata(req_wdata), .bit_idx(bit_idx),
        .words(words)
    );

    pwr_bank_rsp #(.DATA_W(DATA_W)) u_rsp (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .err(acc_err),
        .rdata(rd_word), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );
endmodule

// File: rtl/pwr_ctl_bank_chk.sv
// Port-level properties of the register bank, bound to every instance.
// Assumes req_valid stays low while rst_n is low.
module pwr_ctl_bank_chk #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_secure,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata
);
    logic good_loc, alias_win;
    assign good_loc  = (32'(req_addr[ADDR_W-3:2]) < 32'(NUM_REGS)) && (req_addr[1:0] == 2'b00);
    assign alias_win = req_addr[ADDR_W-1];

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R11
    no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R5
    nonsecure_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure) |=> rsp_err);
    // R8
    reserved_window_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[ADDR_W-1 -: 2] == 2'b01) |=> rsp_err);
    // R9
    bad_bit_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && alias_win && req_wdata >= 32'(DATA_W)) |=> rsp_err);
    // R6
    read_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && good_loc) |=> !rsp_err);
    // R2
    plain_write_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_secure && good_loc
         && req_addr[ADDR_W-1 -: 2] == 2'b00) |=> !rsp_err);
    // R10
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !good_loc) |=> (rsp_err && rsp_rdata == '0));
    // R12
    misaligned_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b00) |=> rsp_err);
endmodule

bind pwr_ctl_bank pwr_ctl_bank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/pwr_ctl_bank_tb.sv
module pwr_ctl_bank_tb;
    localparam int NR = 16;
    localparam logic [1:0] W_PLAIN = 2'b00, W_RSVD = 2'b01, W_CLR = 2'b10, W_SET = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic        got_err;
    logic [31:0] got_data;

    always #4 clk = ~clk;

    pwr_ctl_bank #(.ADDR_W(16), .DATA_W(32), .NUM_REGS(NR)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] adr(input logic [1:0] w, input int word);
        return {w, 12'(word), 2'b00};
    endfunction

    // One request at a falling edge; response sampled one cycle later.
    task automatic access(input logic wr, input logic sec, input logic [15:0] a,
                          input logic [31:0] d);
        req_valid = 1'b1; req_write = wr; req_secure = sec;
        req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got_err = rsp_err;
        got_data = rsp_rdata;
        chk("R11 rsp_valid after request", 32'(rsp_valid), 32'd1);
    endtask

    task automatic rd_word(input int word, input string tag, input logic [31:0] exp);
        access(1'b0, 1'b0, adr(W_PLAIN, word), '0);
        chk(tag, got_data, exp);
        chk({tag, " err"}, 32'(got_err), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid low after reset", 32'(rsp_valid), 32'd0);
        rd_word(0, "R1 word0 zero", 32'h0);
        rd_word(NR-1, "R1 last word zero", 32'h0);
        @(negedge clk);
        chk("R11 rsp_valid low when idle", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_plain;
        access(1'b1, 1'b1, adr(W_PLAIN, 3), 32'hA5A5_0F0F);
        chk("R2 plain write err", 32'(got_err), 32'd0);
        rd_word(3, "R2 R6 plain readback", 32'hA5A5_0F0F);
        access(1'b1, 1'b1, adr(W_PLAIN, 0), 32'h0000_1234);
        access(1'b1, 1'b1, adr(W_PLAIN, NR-1), 32'hFFFF_0001);
        chk("R2 last word write err", 32'(got_err), 32'd0);
        rd_word(NR-1, "R2 last word readback", 32'hFFFF_0001);
    endtask

    task automatic t_set;
        access(1'b1, 1'b1, adr(W_SET, 5), 32'd0);
        chk("R3 set err", 32'(got_err), 32'd0);
        access(1'b1, 1'b1, adr(W_SET, 5), 32'd31);
        access(1'b1, 1'b1, adr(W_SET, 5), 32'd7);
        rd_word(5, "R3 set bits 0,7,31", 32'h8000_0081);
        access(1'b1, 1'b1, adr(W_SET, 5), 32'd7);
        rd_word(5, "R3 set already set bit", 32'h8000_0081);
        rd_word(3, "R3 neighbour word kept", 32'hA5A5_0F0F);
    endtask

    task automatic t_clear;
        access(1'b1, 1'b1, adr(W_CLR, 3), 32'd0);
        chk("R4 clear err", 32'(got_err), 32'd0);
        rd_word(3, "R4 clear bit 0", 32'hA5A5_0F0E);
        access(1'b1, 1'b1, adr(W_CLR, 3), 32'd31);
        rd_word(3, "R4 clear bit 31", 32'h25A5_0F0E);
    endtask

    task automatic t_nonsec;
        access(1'b1, 1'b0, adr(W_PLAIN, 3), 32'h0);
        chk("R5 nonsecure plain err", 32'(got_err), 32'd1);
        access(1'b1, 1'b0, adr(W_SET, 5), 32'd1);
        chk("R5 nonsecure set err", 32'(got_err), 32'd1);
        access(1'b1, 1'b0, adr(W_CLR, 5), 32'd31);
        rd_word(3, "R5 word3 unchanged", 32'h25A5_0F0E);
        rd_word(5, "R5 word5 unchanged", 32'h8000_0081);
    endtask

    task automatic t_alias_read;
        access(1'b0, 1'b0, adr(W_SET, 5), 32'd3);
        chk("R7 read via set window", got_data, 32'h8000_0081);
        chk("R7 read err", 32'(got_err), 32'd0);
        access(1'b0, 1'b1, adr(W_CLR, 5), 32'd0);
        chk("R7 read via clear window", got_data, 32'h8000_0081);
        rd_word(5, "R7 no side effect", 32'h8000_0081);
    endtask

    task automatic t_rsvd;
        access(1'b1, 1'b1, adr(W_RSVD, 3), 32'hFFFF_FFFF);
        chk("R8 reserved window err", 32'(got_err), 32'd1);
        rd_word(3, "R8 word unchanged", 32'h25A5_0F0E);
    endtask

    task automatic t_bad_bit;
        access(1'b1, 1'b1, adr(W_SET, 5), 32'd32);
        chk("R9 bit 32 err", 32'(got_err), 32'd1);
        access(1'b1, 1'b1, adr(W_CLR, 5), 32'hFFFF_FFFF);
        chk("R9 huge bit err", 32'(got_err), 32'd1);
        rd_word(5, "R9 word unchanged", 32'h8000_0081);
        rd_word(0, "R9 word0 unchanged", 32'h0000_1234);
    endtask

    task automatic t_range;
        access(1'b1, 1'b1, adr(W_PLAIN, NR), 32'hDEAD_BEEF);
        chk("R10 plain out of range err", 32'(got_err), 32'd1);
        access(1'b1, 1'b1, adr(W_SET, NR), 32'd20);
        chk("R10 set out of range err", 32'(got_err), 32'd1);
        access(1'b0, 1'b0, adr(W_PLAIN, NR), 32'd0);
        chk("R10 read out of range err", 32'(got_err), 32'd1);
        chk("R10 read out of range data", got_data, 32'h0);
        rd_word(0, "R10 word0 not aliased", 32'h0000_1234);
    endtask

    task automatic t_misaligned;
        access(1'b1, 1'b1, adr(W_PLAIN, 0) | 16'h0002, 32'h5555_5555);
        chk("R12 misaligned write err", 32'(got_err), 32'd1);
        access(1'b0, 1'b0, adr(W_PLAIN, 0) | 16'h0001, 32'd0);
        chk("R12 misaligned read err", 32'(got_err), 32'd1);
        chk("R12 misaligned read data", got_data, 32'h0);
        rd_word(0, "R12 word0 unchanged", 32'h0000_1234);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_set();
        t_clear();
        t_nonsec();
        t_alias_read();
        t_rsvd();
        t_bad_bit();
        t_range();
        t_misaligned();
        @(negedge clk);
        chk("R11 rsp_valid low at end", 32'(rsp_valid), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule